// File: doc/BRIEF.md
# Shared Exclusive Reservation Monitor

This block keeps one reservation per requester for a memory system that several requesters use at once. A requester opens a reservation with a load-exclusive. It later asks, with a store-exclusive, whether the reservation still holds. The monitor gives its verdict one cycle later. A passing store-exclusive may commit, and a failing one must be retried. Any ordinary store ends every open reservation.

A passing store-exclusive also drops the reservations of other requesters that fall in the same 16-byte granule. An exact-address store-exclusive can still fail on purpose: a per-requester counter makes one attempt fail after a fixed run of exact matches. Software retry loops therefore see the same kind of spurious failure that real cache hardware produces.

Only one access event is presented per cycle. The event codes on `acc_op` are: 0 = ordinary load, 1 = ordinary store, 2 = load-exclusive, 3 = store-exclusive.

Top module: `excl_monitor`

## Requirements
- R1: After reset, every reservation is open (`resv_mask` = 0), every tag is zero, every failure counter is zero, and `sx_done` is low.
- R2: A load-exclusive (`acc_op` = 2) from requester i sets bit i of `resv_mask` on the next cycle. It records the full address as that requester's tag.
- R3: An ordinary store (`acc_op` = 1) from any requester clears all bits of `resv_mask` on the next cycle, whatever the address.
- R4: An ordinary load (`acc_op` = 0) changes no reservation, no tag and no verdict.
- R5: A store-exclusive (`acc_op` = 3) from a requester whose reservation is open fails.
- R6: A store-exclusive whose address differs in any bit from the requester's tag fails, and the reservation stays set.
- R7: A store-exclusive whose address equals the requester's tag exactly clears that requester's reservation. It passes unless R8 applies.
- R8: On each exact match the requester's counter is compared with MAX_FAIL. If the counter is below MAX_FAIL, it increments and the store passes. If it has reached MAX_FAIL, it returns to zero and the store fails. With the default of 5, the sixth exact match after reset fails.
- R9: A passing store-exclusive clears every other set reservation whose tag agrees with the store address above bit GRAN_BITS (default 4). A failing store-exclusive clears no other reservation.
- R10: `sx_done` is high for exactly the one cycle after each store-exclusive, and only then. `sx_pass` is high only together with `sx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access event is presented this cycle |
| acc_id | input | $clog2(N) | Requester issuing the event |
| acc_op | input | 2 | Event code: 0 load, 1 store, 2 load-exclusive, 3 store-exclusive |
| acc_addr | input | AW | Byte address of the event |
| sx_done | output | 1 | Store-exclusive verdict valid |
| sx_pass | output | 1 | Store-exclusive may commit |
| resv_mask | output | N | Bit i set while requester i holds a reservation |

## Verification
Store-exclusives are tried with the requester's reservation open, with an address one word off the tag, and with an exact match. These three patterns separate the open-state failure, the mismatch failure that keeps the reservation, and the clearing pass. Several requesters reserve addresses in the same granule and in a neighbouring granule. This shows the coarse cross-clear after a pass, and shows that no cross-clear happens after a counter-forced failure. Repeated exact matches on one requester find the run length at which the forced failure fires. Long random mixes over a few nearby addresses then exercise the interaction of stores, loads and counters.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int N         = 4,
  parameter int AW        = 32,
  parameter int GRAN_BITS = 4,
  parameter int MAX_FAIL  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic [$clog2(N)-1:0] acc_id,
  input  logic [1:0]           acc_op,
  input  logic [AW-1:0]        acc_addr,
  output logic                 sx_done,
  output logic                 sx_pass,
  output logic [N-1:0]         resv_mask
);
  localparam int CW = $clog2(MAX_FAIL + 1);
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LX = 2'd2, OP_SX = 2'd3;

  logic [AW-1:0] tag [N];
  logic [CW-1:0] cnt [N];

  logic own_hit, forced_fail;
  assign own_hit     = resv_mask[acc_id] && (tag[acc_id] == acc_addr);
  assign forced_fail = cnt[acc_id] >= CW'(MAX_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sx_done   <= 1'b0;
      sx_pass   <= 1'b0;
      resv_mask <= '0;
      for (int i = 0; i < N; i++) begin
        tag[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      sx_done <= 1'b0;
      sx_pass <= 1'b0;
      if (acc_valid) begin
        case (acc_op)
          OP_ST: resv_mask <= '0;
          OP_LX: begin
            resv_mask[acc_id] <= 1'b1;
            tag[acc_id]       <= acc_addr;
          end
          OP_SX: begin
            sx_done <= 1'b1;
            if (own_hit) begin
              resv_mask[acc_id] <= 1'b0;
              if (forced_fail) begin
                cnt[acc_id] <= '0;
              end else begin
                cnt[acc_id] <= cnt[acc_id] + 1'b1;
                sx_pass     <= 1'b1;
                for (int j = 0; j < N; j++)
                  if (j != int'(acc_id) &&
                      tag[j][AW-1:GRAN_BITS] == acc_addr[AW-1:GRAN_BITS])
                    resv_mask[j] <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module excl_monitor_chk #(
  parameter int N  = 4,
  parameter int AW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic [$clog2(N)-1:0] acc_id,
  input logic [1:0]           acc_op,
  input logic [AW-1:0]        acc_addr,
  input logic                 sx_done,
  input logic                 sx_pass,
  input logic [N-1:0]         resv_mask
);
  // R10
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sx_pass |-> sx_done);
  // R10
  done_after_sx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == 2'd3) |=> sx_done);
  // R10
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_op == 2'd3) |=> !sx_done);
  // R3
  store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == 2'd1) |=> (resv_mask == '0));
  // R2
  lx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == 2'd2) |=> resv_mask[$past(acc_id)]);
  // R5
  open_sx_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == 2'd3 && !resv_mask[acc_id]) |=> !sx_pass);
  // R4
  load_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == 2'd0) |=> ($stable(resv_mask) && !sx_done));
endmodule

bind excl_monitor excl_monitor_chk #(.N(N), .AW(AW)) u_chk (.*);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
  localparam int N = 4, AW = 32, GB = 4, MAXF = 5;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0;
  logic [IW-1:0] acc_id = '0;
  logic [1:0] acc_op = '0;
  logic [AW-1:0] acc_addr = '0;
  logic sx_done, sx_pass;
  logic [N-1:0] resv_mask;

  excl_monitor #(.N(N), .AW(AW), .GRAN_BITS(GB), .MAX_FAIL(MAXF)) u_excl_monitor (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic        m_ex  [N];
  logic [AW-1:0] m_tag [N];
  int          m_cnt [N];

  function automatic logic [N-1:0] m_mask();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = m_ex[i];
    return m;
  endfunction

  task automatic check(string req, logic done, logic pass, logic [N-1:0] mask,
                       logic edone, logic epass, logic [N-1:0] emask);
    checks++;
    if (done !== edone || pass !== epass || mask !== emask) begin
      fails++;
      $display("FAIL %s: done/pass/mask got %b/%b/%b expected %b/%b/%b",
               req, done, pass, mask, edone, epass, emask);
    end
  endtask

  task automatic apply(int id, logic [1:0] op, logic [AW-1:0] addr, string req);
    logic ed = 0, ep = 0;
    string tag = req;
    case (op)
      2'd1: for (int i = 0; i < N; i++) m_ex[i] = 0;
      2'd2: begin m_ex[id] = 1; m_tag[id] = addr; end
      2'd3: begin
        ed = 1;
        if (m_ex[id] && m_tag[id] == addr) begin
          m_ex[id] = 0;
          if (m_cnt[id] >= MAXF) m_cnt[id] = 0;
          else begin
            m_cnt[id]++;
            ep = 1;
            for (int j = 0; j < N; j++)
              if (j != id && m_tag[j][AW-1:GB] == addr[AW-1:GB]) m_ex[j] = 0;
          end
        end
      end
      default: ;
    endcase
    @(negedge clk);
    acc_valid = 1; acc_id = IW'(id); acc_op = op; acc_addr = addr;
    @(posedge clk); #1;
    acc_valid = 0;
    check(tag, sx_done, sx_pass, resv_mask, ed, ep, m_mask());
  endtask

  task automatic idle(string req);
    @(negedge clk);
    @(posedge clk); #1;
    check(req, sx_done, sx_pass, resv_mask, 1'b0, 1'b0, m_mask());
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_ex[i] = 0; m_tag[i] = '0; m_cnt[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1", sx_done, sx_pass, resv_mask, 1'b0, 1'b0, '0);
    @(negedge clk) rst_n = 1;
    idle("R1");
    apply(0, 2'd3, 32'h1000, "R5");
    idle("R10");
    apply(0, 2'd2, 32'h1000, "R2");
    apply(1, 2'd0, 32'h1000, "R4");
    apply(0, 2'd3, 32'h1004, "R6");
    apply(1, 2'd2, 32'h1008, "R2");
    apply(2, 2'd2, 32'h1010, "R2");
    apply(0, 2'd3, 32'h1000, "R7_R9");
    apply(3, 2'd1, 32'h2000, "R3");
    for (int k = 0; k < MAXF - 1; k++) begin
      apply(0, 2'd2, 32'h1000, "R2");
      apply(0, 2'd3, 32'h1000, "R8_pass");
    end
    apply(0, 2'd2, 32'h1000, "R2");
    apply(1, 2'd2, 32'h1000, "R2");
    apply(0, 2'd3, 32'h1000, "R8_fail");
    apply(1, 2'd3, 32'h1000, "R9_nofail_clear");
    apply(0, 2'd2, 32'h1000, "R2");
    apply(0, 2'd3, 32'h1000, "R8_restart");

    void'($urandom(32'd4242));
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(99);
      int id = $urandom_range(N - 1);
      logic [AW-1:0] a = 32'h1000 + 4 * $urandom_range(7);
      logic [1:0] op = (r < 40) ? 2'd2 : (r < 80) ? 2'd3 : (r < 88) ? 2'd1 : 2'd0;
      string lbl;
      case (op)
        2'd0: lbl = "R4";
        2'd1: lbl = "R3";
        2'd2: lbl = "R2";
        default: lbl = !m_ex[id] ? "R5" : (m_tag[id] != a) ? "R6" :
                       (m_cnt[id] >= MAXF) ? "R8" : "R7_R9";
      endcase
      apply(id, op, a, lbl);
      if (r % 10 == 0) idle("R10");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule